// File: doc/BRIEF.md
# SPI Target Port with Resend-on-Late-Write

This block is the receiving end of a four-wire serial peripheral link. An external controller drives the serial clock, an active-low select and the controller-to-target data line. The block answers on the target-to-controller data line. Every clock period moves one bit each way, so one word goes out while another comes in. The serial clock idles low. A phase input chooses when a word starts. With phase 0 it starts at the falling edge of select. With phase 1 it starts at the first rising clock edge seen while select is low.

On the system side, a write port supplies the next outgoing word. The received word sits in a register, and a one-cycle strobe marks its arrival. The design copies the outgoing word into the shift register at the instant a word starts. If nothing new was written before that instant, the previous word is copied again and resent. A write made while a word is on the wire is parked. It becomes the outgoing word once that transfer is over. The return line can be driven both ways, or it can behave as open drain and only pull low, so that several targets can share one line with a pull-up.

All pin inputs pass through two-stage synchronisers and are edge-detected in the system clock domain. For this reason the system clock must run at least four times faster than the serial clock.

Top module: `spi_tgt_port`

## Requirements
- R1: Transfers are full duplex and most-significant bit first. After a complete word of W bits, `rx_data` holds the W bits taken from `mosi_i`, first bit in bit W-1. In the same transfer the bits sent on the return line form the outgoing word, starting with bit W-1.
- R2: With `cfg_cpha` = 0, the falling edge of `ssn_i` starts a word. Bit W-1 of the outgoing word appears on the return line within 6 system clocks of that edge, before any serial clock edge. Incoming bits are taken on rising edges of `sclk_i`, and the next outgoing bit is presented on falling edges.
- R3: With `cfg_cpha` = 1, the first rising edge of `sclk_i` while `ssn_i` is low starts a word and presents bit W-1. Later rising edges present the following bits. Incoming bits are taken on falling edges.
- R4: If no host write has happened since the previous word started, the next word sends the same outgoing word again.
- R5: A host write made while a word is in progress does not change the bits of that word. The written value is sent by the following word.
- R6: When the W-th bit of a word is taken, `rx_data` is updated and `rx_full` is high for exactly one system clock. `rx_data` keeps its value until the next complete word.
- R7: If `ssn_i` rises before a word is complete, `rx_data` keeps its value, `rx_full` does not pulse, and the next word starts counting bits from zero.
- R8: `tx_empty` is 1 after reset. A host write clears it. It is set when the outgoing word is copied into the shift register at the start of a word. A write parked during a word clears it again when that word ends.
- R9: With `cfg_odrain` = 1, `miso_o` is never 1. The line is driven low (`miso_oe` = 1) for a 0 bit and released (`miso_oe` = 0) for a 1 bit. With `cfg_odrain` = 0 and select low, `miso_oe` = 1 and `miso_o` carries the bit.
- R10: While `ssn_i` is high, after at most 4 system clocks, `miso_oe` is 0 whatever `cfg_odrain` is.
- R11: Reset (`rst` high at a rising clock edge) gives `rx_data` = 0, `rx_full` = 0, `tx_empty` = 1, `miso_oe` = 0 and `miso_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpha | input | 1 | Clock phase: 0 = select edge starts a word, 1 = first rising clock starts a word |
| cfg_odrain | input | 1 | 1 = return line is pull-low only, 0 = push-pull |
| sclk_i | input | 1 | Serial clock from the controller, idle low |
| ssn_i | input | 1 | Active-low target select |
| mosi_i | input | 1 | Serial data from the controller |
| miso_o | output | 1 | Serial data value toward the controller |
| miso_oe | output | 1 | Output enable for the return line |
| wr_en | input | 1 | Host write strobe for the outgoing word |
| wr_data | input | W | Outgoing word from the host |
| rx_data | output | W | Last completely received word |
| rx_full | output | 1 | One-cycle strobe: a new word is in `rx_data` |
| tx_empty | output | 1 | The outgoing word has been taken by the shift register |

## Verification
The bench builds the port with W = 8 and two synchroniser stages. It runs the serial clock at sixteen system clocks per period, so each synchronised edge is well clear of the next. These settings let it cover the extreme patterns 00 and FF and mixed patterns in both phases and both drive styles. They also let it place a host write and a select release at chosen bit positions within a word. A pull-up model on the return line makes open-drain zeros and ones visible as plain bit values.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  // Pin events after synchronisation, all in the system clock domain
  typedef struct packed {
    logic sel;        // select is active (pin low)
    logic sel_fall;   // select pin went low this cycle
    logic sclk_rise;  // serial clock rising edge seen
    logic sclk_fall;  // serial clock falling edge seen
    logic mosi;       // data line aligned with the clock events
  } pin_ev_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk_i,
  input  logic                 ssn_i,
  input  logic                 mosi_i,
  output spi_tgt_pkg::pin_ev_t ev
);

  logic sclk_s, ssn_s, mosi_s;
  logic sclk_d, ssn_d;

  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_s <= 1'b0;
          ssn_s  <= 1'b1;
          mosi_s <= 1'b0;
        end else begin
          sclk_s <= sclk_i;
          ssn_s  <= ssn_i;
          mosi_s <= mosi_i;
        end
      end
    end else begin : g_chain
      logic [STAGES-1:0] sclk_ff, ssn_ff, mosi_ff;
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_ff <= '0;
          ssn_ff  <= '1;
          mosi_ff <= '0;
        end else begin
          sclk_ff <= {sclk_ff[STAGES-2:0], sclk_i};
          ssn_ff  <= {ssn_ff[STAGES-2:0], ssn_i};
          mosi_ff <= {mosi_ff[STAGES-2:0], mosi_i};
        end
      end
      assign sclk_s = sclk_ff[STAGES-1];
      assign ssn_s  = ssn_ff[STAGES-1];
      assign mosi_s = mosi_ff[STAGES-1];
    end
  endgenerate

  // One more register per control line for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      ssn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      ssn_d  <= ssn_s;
    end
  end

  always_comb begin
    ev.sel       = ~ssn_s;
    ev.sel_fall  = ~ssn_s & ssn_d;
    ev.sclk_rise = sclk_s & ~sclk_d;
    ev.sclk_fall = ~sclk_s & sclk_d;
    ev.mosi      = mosi_s;
  end

endmodule

// File: rtl/spi_tgt_txbuf.sv
module spi_tgt_txbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         busy,
  input  logic         xfer_start,
  input  logic         xfer_end,
  output logic [W-1:0] hold_word,
  output logic         tx_empty
);

  logic [W-1:0] hold_q, park_q;
  logic         park_v_q;
  logic         empty_q;
  logic         in_xfer;

  // A write is parked if a word is on the wire or begins in this cycle
  assign in_xfer = (busy & ~xfer_end) | xfer_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      park_q   <= '0;
      park_v_q <= 1'b0;
      empty_q  <= 1'b1;
    end else begin
      if (xfer_start) begin
        empty_q <= 1'b1;
      end
      if (wr_en && !in_xfer) begin
        hold_q   <= wr_data;
        park_v_q <= 1'b0;
        empty_q  <= 1'b0;
      end else if (wr_en) begin
        park_q   <= wr_data;
        park_v_q <= 1'b1;
      end
      if (xfer_end && park_v_q && !wr_en) begin
        hold_q   <= park_q;
        park_v_q <= 1'b0;
        empty_q  <= 1'b0;
      end
    end
  end

  assign hold_word = hold_q;
  assign tx_empty  = empty_q;

  // R5: the word being sent stays fixed while a transfer runs
  a_r5_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && !xfer_end) |=> $stable(hold_q));

  // R8: starting a word always leaves the empty flag set
  a_r8_start_sets_empty: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> empty_q);

endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  spi_tgt_pkg::pin_ev_t ev,
  input  logic                 cpha,
  input  logic [W-1:0]         load_word,
  output logic                 busy,
  output logic                 xfer_start,
  output logic                 xfer_end,
  output logic                 tx_bit,
  output logic [W-1:0]         rx_word,
  output logic                 rx_full
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  tx_sh_q, rx_sh_q, rx_word_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, rx_full_q;
  logic          drive_edge, sample_edge, abort, complete;

  // Phase 1 presents on rising and takes on falling; phase 0 the reverse
  assign drive_edge  = cpha ? ev.sclk_rise : ev.sclk_fall;
  assign sample_edge = cpha ? ev.sclk_fall : ev.sclk_rise;
  assign xfer_start  = ~busy_q & ev.sel & (cpha ? ev.sclk_rise : ev.sel_fall);
  assign abort       = busy_q & ~ev.sel;
  assign complete    = busy_q & ev.sel & sample_edge & (cnt_q == LAST);
  assign xfer_end    = abort | complete;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_word_q <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      rx_full_q <= 1'b0;
    end else begin
      rx_full_q <= 1'b0;
      if (xfer_start) begin
        tx_sh_q <= load_word;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
      end else if (abort) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (drive_edge) begin
          tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
        end
        if (sample_edge) begin
          rx_sh_q <= {rx_sh_q[W-2:0], ev.mosi};
          cnt_q   <= cnt_q + 1'b1;
          if (complete) begin
            rx_word_q <= {rx_sh_q[W-2:0], ev.mosi};
            rx_full_q <= 1'b1;
            busy_q    <= 1'b0;
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign tx_bit  = tx_sh_q[W-1];
  assign rx_word = rx_word_q;
  assign rx_full = rx_full_q;

  // R6: the arrival strobe never lasts two cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_full_q |=> !rx_full_q);

  // R7: a cut-short word neither strobes nor changes the received word
  a_r7_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!rx_full_q && $stable(rx_word_q)));

  // R1: a bit count at the last position only exists while a word runs
  a_r1_count_in_word: assert property (@(posedge clk) disable iff (rst)
    (busy_q && sample_edge && ev.sel && cnt_q == LAST) |=> !busy_q);

endmodule

// File: rtl/spi_tgt_port.sv
module spi_tgt_port #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_cpha,
  input  logic         cfg_odrain,
  input  logic         sclk_i,
  input  logic         ssn_i,
  input  logic         mosi_i,
  output logic         miso_o,
  output logic         miso_oe,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rx_data,
  output logic         rx_full,
  output logic         tx_empty
);

  spi_tgt_pkg::pin_ev_t ev;
  logic [W-1:0] hold_word;
  logic         busy, xfer_start, xfer_end, tx_bit;
  logic         sel_now;
  logic         miso_q, miso_oe_q;

  spi_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .sclk_i (sclk_i),
    .ssn_i  (ssn_i),
    .mosi_i (mosi_i),
    .ev     (ev)
  );

  spi_tgt_txbuf #(.W(W)) u_txbuf (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .busy       (busy),
    .xfer_start (xfer_start),
    .xfer_end   (xfer_end),
    .hold_word  (hold_word),
    .tx_empty   (tx_empty)
  );

  spi_tgt_engine #(.W(W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .cpha       (cfg_cpha),
    .load_word  (hold_word),
    .busy       (busy),
    .xfer_start (xfer_start),
    .xfer_end   (xfer_end),
    .tx_bit     (tx_bit),
    .rx_word    (rx_data),
    .rx_full    (rx_full)
  );

  assign sel_now = ev.sel;

  // Registered pad drive: push-pull, pull-low only, or released
  always_ff @(posedge clk) begin
    if (rst) begin
      miso_q    <= 1'b0;
      miso_oe_q <= 1'b0;
    end else begin
      miso_oe_q <= sel_now & (cfg_odrain ? ~tx_bit : 1'b1);
      miso_q    <= sel_now & ~cfg_odrain & tx_bit;
    end
  end

  assign miso_o  = miso_q;
  assign miso_oe = miso_oe_q;

  // R9: in pull-low mode a high level is never driven
  a_r9_od_never_high: assert property (@(posedge clk) disable iff (rst)
    miso_q |-> !$past(cfg_odrain));

  // R10: the line is only enabled while the target was selected
  a_r10_release_idle: assert property (@(posedge clk) disable iff (rst)
    miso_oe_q |-> $past(sel_now));

endmodule

// File: tb/spi_tgt_port_test.sv
module spi_tgt_port_test;

  localparam int W    = 8;
  localparam int HALF = 8;

  // {cpha, odrain, do_write, tx word, mosi word, expected line word, expected rx}
  localparam logic [34:0] VECS [8] = '{
    {1'b0, 1'b0, 1'b1, 8'hA5, 8'h3C, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 1'b1, 8'h96, 8'hC3, 8'h96, 8'hC3},
    {1'b0, 1'b0, 1'b0, 8'h00, 8'h5A, 8'h96, 8'h5A},
    {1'b1, 1'b1, 1'b1, 8'h0F, 8'hF0, 8'h0F, 8'hF0},
    {1'b0, 1'b1, 1'b1, 8'h81, 8'h7E, 8'h81, 8'h7E},
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h81, 8'h00},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 8'h00, 8'hFF},
    {1'b1, 1'b1, 1'b1, 8'hFF, 8'h01, 8'hFF, 8'h01}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_cpha = 1'b0;
  logic         cfg_odrain = 1'b0;
  logic         sclk = 1'b0;
  logic         ssn = 1'b1;
  logic         mosi = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         miso_o, miso_oe, rx_full, tx_empty;
  logic [W-1:0] rx_data;

  always #5 clk = ~clk;

  spi_tgt_port #(.W(W), .SYNC_STAGES(2)) uut (
    .clk        (clk),
    .rst        (rst),
    .cfg_cpha   (cfg_cpha),
    .cfg_odrain (cfg_odrain),
    .sclk_i     (sclk),
    .ssn_i      (ssn),
    .mosi_i     (mosi),
    .miso_o     (miso_o),
    .miso_oe    (miso_oe),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .tx_empty   (tx_empty)
  );

  int           total = 0;
  int           bad = 0;
  int           rx_pulses = 0;
  int           dbl = 0;
  int           od_hi = 0;
  logic [W-1:0] rx_last = '0;
  logic         prev_full = 1'b0;
  bit           done = 1'b0;

  // Port monitors
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_full) begin
        rx_pulses = rx_pulses + 1;
        rx_last = rx_data;
      end
      if (rx_full && prev_full) dbl = dbl + 1;
      if (cfg_odrain && miso_o) od_hi = od_hi + 1;
      prev_full = rx_full;
    end
  end

  // Return line with a pull-up
  function automatic logic line();
    return miso_oe ? miso_o : 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Controller model: nbits clock periods, optional host write before bit wr_at
  task automatic xfer(input logic ph, input logic [W-1:0] mo, input int nbits,
                      input int wr_at, input logic [W-1:0] wd, output logic [W-1:0] mi);
    mi = '0;
    @(negedge clk);
    cfg_cpha = ph;
    @(negedge clk);
    ssn = 1'b0;
    sclk = 1'b0;
    mosi = ph ? 1'b0 : mo[W-1];
    idle(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (i == wr_at) host_wr(wd);
      if (!ph) begin
        mi[W-1-i] = line();
        sclk = 1'b1;
        idle(HALF);
        sclk = 1'b0;
        if (i < W-1) mosi = mo[W-2-i];
        idle(HALF);
      end else begin
        sclk = 1'b1;
        mosi = mo[W-1-i];
        idle(HALF);
        mi[W-1-i] = line();
        sclk = 1'b0;
        idle(HALF);
      end
    end
    ssn = 1'b1;
    idle(3*HALF);
  endtask

  initial begin
    logic [34:0]  v;
    logic [W-1:0] got;
    string        tag;
    int           p0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R11: reset state
    chk(rx_data == 8'h00, "R11 rx_data", rx_data, 0);
    chk(rx_full == 1'b0, "R11 rx_full", rx_full, 0);
    chk(tx_empty == 1'b1, "R11 tx_empty", tx_empty, 1);
    chk(miso_oe == 1'b0 && miso_o == 1'b0, "R11 miso", {miso_oe, miso_o}, 0);

    // Vector table: both phases, both drive styles, resend cases
    for (int k = 0; k < 8; k++) begin
      v = VECS[k];
      tag = v[34] ? "R3" : "R2";
      cfg_odrain = v[33];
      if (v[32]) begin
        host_wr(v[31:24]);
        chk(tx_empty == 1'b0, "R8 write clears", tx_empty, 0);
      end else begin
        chk(tx_empty == 1'b1, "R4 no write, flag stays", tx_empty, 1);
      end
      p0 = rx_pulses;
      xfer(v[34], v[23:16], W, -1, '0, got);
      chk(got == v[15:8], {tag, " R1 R4 line word"}, got, v[15:8]);
      chk(rx_last == v[7:0], {tag, " R1 rx word"}, rx_last, v[7:0]);
      chk(rx_data == v[7:0], "R6 rx_data held", rx_data, v[7:0]);
      chk(rx_pulses == p0 + 1, "R6 one strobe", rx_pulses - p0, 1);
      chk(tx_empty == 1'b1, "R8 start sets empty", tx_empty, 1);
    end
    chk(od_hi == 0, "R9 no high in pull-low mode", od_hi, 0);
    chk(dbl == 0, "R6 strobe width", dbl, 0);
    chk(miso_oe == 1'b0, "R10 released when idle", miso_oe, 0);

    // R2: first bit before any clock edge, push-pull, then cut short (R7)
    cfg_odrain = 1'b0;
    host_wr(8'h40);
    @(negedge clk);
    cfg_cpha = 1'b0;
    @(negedge clk);
    ssn = 1'b0;
    idle(6);
    chk(miso_oe == 1'b1 && miso_o == 1'b0, "R2 first bit 0", {miso_oe, miso_o}, 2'b10);
    p0 = rx_pulses;
    ssn = 1'b1;
    idle(3*HALF);
    chk(rx_pulses == p0, "R7 no strobe", rx_pulses - p0, 0);
    chk(rx_data == 8'h01, "R7 rx kept", rx_data, 8'h01);
    chk(miso_oe == 1'b0, "R10 released after select high", miso_oe, 0);

    // R4: resend after the cut-short word
    xfer(1'b0, 8'h99, W, -1, '0, got);
    chk(got == 8'h40, "R4 resend", got, 8'h40);
    chk(rx_last == 8'h99, "R1 rx after abort", rx_last, 8'h99);

    // R7: abort half way in phase 1, then a full word counts from zero
    p0 = rx_pulses;
    xfer(1'b1, 8'h66, 4, -1, '0, got);
    chk(rx_pulses == p0, "R7 mid-word no strobe", rx_pulses - p0, 0);
    chk(rx_data == 8'h99, "R7 mid-word rx kept", rx_data, 8'h99);
    xfer(1'b1, 8'h5A, W, -1, '0, got);
    chk(rx_last == 8'h5A, "R7 count restarts", rx_last, 8'h5A);
    chk(got == 8'h40, "R4 resend again", got, 8'h40);

    // R5: write during a word is parked, sent by the next word
    host_wr(8'h11);
    xfer(1'b1, 8'hE7, W, 3, 8'h22, got);
    chk(got == 8'h11, "R5 word unchanged", got, 8'h11);
    chk(tx_empty == 1'b0, "R8 parked write clears at end", tx_empty, 0);
    xfer(1'b0, 8'h18, W, -1, '0, got);
    chk(got == 8'h22, "R5 parked word sent", got, 8'h22);
    chk(rx_last == 8'h18, "R1 rx phase 0", rx_last, 8'h18);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule